// File: doc/BRIEF.md
# Multiplexed external memory bus sequencer

This block drives the external memory bus of an 8-bit controller. A 12-clock machine cycle is divided into two 6-clock halves. In a fetch cycle each half begins with an address latch pulse. During that pulse the shared byte lane carries the low byte of the program counter. The second part of each half is a program-store read window, in which the lane is released to the memory.

When the core places a data-memory request at a machine-cycle boundary, the following machine cycle becomes a data cycle. It keeps the first address latch pulse and carries the data address on the lane. It drops the second latch pulse and both program-store reads. In its second half it asserts a dedicated read or write strobe for six clocks. The high address byte comes either from the 16-bit pointer or from the port-2 output register, depending on the access mode.

The lane is modelled as split pad signals (output value, output enable, input value). A latch on the low address byte, which stands in for the external latch, is brought out as its own output.

Top module: `xbus_seq`

## Requirements
- R1: In a fetch cycle `ale_o` is high at positions 0, 1, 6 and 7 of the 12-clock machine cycle and low elsewhere, which gives two pulses per cycle (one per six clocks).
- R2: In a fetch cycle `psen_n_o` is low at positions 3–5 and 9–11 and high elsewhere, which gives two read windows per machine cycle.
- R3: In a fetch cycle `ad_oe_o` is 1 with `ad_o` equal to `pc_i[7:0]` at positions 0–2 and 6–8, and `ad_oe_o` is 0 at positions 3–5 and 9–11. `addr_hi_o` equals `pc_i[15:8]`.
- R4: `addr_lo_o` takes the lane value `ad_o` present in the last clock of each `ale_o` pulse and shows it from the following clock onward.
- R5: A request (`req_i` = 1) is sampled only at position 11. If it is accepted, `grant_o` is high for one clock at position 0 of the data cycle. A request that is dropped before position 11 is ignored, and the fetch pattern continues.
- R6: In a data cycle `ale_o` is high only at positions 0–1, so one latch pulse is omitted, and `psen_n_o` stays high for all 12 clocks, so two read windows are omitted.
- R7: In a data cycle `addr_hi_o` equals `req_addr_i[15:8]` when `req_wide_i` = 1 and equals `p2_reg_i` when `req_wide_i` = 0. Both values are taken at acceptance and held for the whole cycle. The lane drives `req_addr_i[7:0]` with `ad_oe_o` = 1 at positions 0–5.
- R8: In a read cycle (`req_we_i` = 0) `rd_n_o` is low at positions 6–11, `wr_n_o` stays high, and `ad_oe_o` is 0 at positions 6–11.
- R9: In a read cycle `ad_i` is sampled on the clock edge that ends position 10. The sampled value appears on `rdata_o`, and `done_o` is high for one clock at position 0 after the cycle.
- R10: In a write cycle (`req_we_i` = 1) `wr_n_o` is low at positions 6–11 and `rd_n_o` stays high. The lane drives `req_wdata_i` with `ad_oe_o` = 1 at positions 6–11. `done_o` pulses at position 0 after the cycle.
- R11: Reset is synchronous and active low. While it is low, `ale_o` and `ad_oe_o` are 0, and `psen_n_o`, `rd_n_o` and `wr_n_o` are 1. The first clock after release is position 0 of a fetch cycle.
- R12: A request held high across consecutive boundaries produces back-to-back data cycles with no fetch cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 16 | Program fetch address from the core |
| req_i | input | 1 | Data-memory access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit register address |
| req_addr_i | input | 16 | Data access address |
| req_wdata_i | input | 8 | Write data |
| p2_reg_i | input | 8 | Port-2 output register contents |
| grant_o | output | 1 | Request accepted, high at position 0 of the data cycle |
| done_o | output | 1 | Data cycle finished, high at position 0 after it |
| rdata_o | output | 8 | Captured read data |
| ale_o | output | 1 | Address latch enable |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| addr_hi_o | output | 8 | High address byte |
| addr_lo_o | output | 8 | Latched low address byte |
| ad_o | output | 8 | Lane output value |
| ad_oe_o | output | 1 | Lane output enable |
| ad_i | input | 8 | Lane input value |

## Verification
The strobes, the lane and the high address byte are decoded from the position register without a further stage. They are therefore due in the same clock period as the position that defines them. The bench keeps its own position count from the release of reset and samples on falling edges once it has reached the intended position. `grant_o` and `done_o` are registered at the boundary edge and are checked at the following position 0. `addr_lo_o` is checked one position after the last latch clock. The read value is offered only during position 10 and is corrupted before and after that position, so `rdata_o` is correct at the next position 0 only if the sample was taken on the edge that ends position 10.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus sequencer.
package xbus_pkg;
    // Kind of the machine cycle currently on the bus.
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } kind_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
// Position counter for the machine cycle.
// Counts 0..CYC-1 once running. After reset is released, one clock arms the
// counter, and that clock already shows position 0.
// Assumes: NUM_STATES is even, and STATE_CLKS >= 1.
module xbus_phase_ctr #(
    parameter int STATE_CLKS = 2,
    parameter int NUM_STATES = 6,
    parameter int CYC        = STATE_CLKS * NUM_STATES,
    parameter int CW         = $clog2(CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          live_o,
    output logic [CW-1:0] pos_o,
    output logic          last_o
);
    localparam logic [CW-1:0] LAST_C = CW'(CYC - 1);

    // Arm after reset, then advance the position and wrap it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_o <= 1'b0;
            pos_o  <= '0;
        end else if (!live_o) begin
            live_o <= 1'b1;
        end else if (pos_o == LAST_C) begin
            pos_o <= '0;
        end else begin
            pos_o <= pos_o + 1'b1;
        end
    end

    // Boundary marker: last clock of a running machine cycle.
    always_comb last_o = live_o && (pos_o == LAST_C);

    p_pos_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= LAST_C);
    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (pos_o == '0));
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !live_o |-> (pos_o == '0));
endmodule

// File: rtl/xbus_access_ctl.sv
// Access control: samples a data request at the cycle boundary and holds
// its fields for the whole data cycle. It also produces grant and done
// pulses and captures read data.
// Assumes: ADDR_W == 2*DATA_W. The request fields are valid whenever
// req_i is high.
module xbus_access_ctl
    import xbus_pkg::*;
#(
    parameter int STATE_CLKS = 2,
    parameter int NUM_STATES = 6,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CYC        = STATE_CLKS * NUM_STATES,
    parameter int CW         = $clog2(CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_i,
    input  logic [CW-1:0]     pos_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic              req_wide_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] p2_reg_i,
    input  logic [DATA_W-1:0] ad_i,
    output kind_e             kind_o,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              grant_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [CW-1:0] SAMPLE_C = CW'(CYC - 2);

    // Latch the next cycle's kind and fields at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_o  <= KIND_FETCH;
            hi_o    <= '0;
            lo_o    <= '0;
            wdata_o <= '0;
        end else if (last_i) begin
            if (req_i) begin
                kind_o  <= req_we_i ? KIND_WRITE : KIND_READ;
                hi_o    <= req_wide_i ? req_addr_i[ADDR_W-1:DATA_W] : p2_reg_i;
                lo_o    <= req_addr_i[DATA_W-1:0];
                wdata_o <= req_wdata_i;
            end else begin
                kind_o <= KIND_FETCH;
            end
        end
    end

    // Grant and done pulses, both on the boundary edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            grant_o <= last_i && req_i;
            done_o  <= last_i && (kind_o != KIND_FETCH);
        end
    end

    // Capture the lane one clock before the read strobe is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (kind_o == KIND_READ && pos_i == SAMPLE_C) begin
            rdata_o <= ad_i;
        end
    end

    p_grant_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> $past(last_i));
    p_kind_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(last_i) |-> $stable(kind_o));
    p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(kind_o) != KIND_FETCH));
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(kind_o) == KIND_READ && $past(pos_i) == SAMPLE_C) |-> $stable(rdata_o));
endmodule

// File: rtl/xbus_strobe_gen.sv
// Strobe and lane decode. It turns the position and the cycle kind into
// the address latch, program-store, read and write strobes. It also muxes
// the lane and the high byte, and models the external low-address latch.
// Assumes: the kind and its fields change only at the boundary.
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int STATE_CLKS = 2,
    parameter int NUM_STATES = 6,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CYC        = STATE_CLKS * NUM_STATES,
    parameter int CW         = $clog2(CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live_i,
    input  logic [CW-1:0]     pos_i,
    input  kind_e             kind_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              ale_o,
    output logic              psen_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] addr_hi_o,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o
);
    localparam int HALF = CYC / 2;
    localparam logic [CW-1:0] HALF_C    = CW'(HALF);
    localparam logic [CW-1:0] QTR_C     = CW'(HALF / 2);
    localparam logic [CW-1:0] ALE_LEN_C = CW'(STATE_CLKS);
    localparam logic [CW-1:0] ALE_END_C = CW'(STATE_CLKS - 1);

    logic          upper;
    logic [CW-1:0] ph;
    logic          fetch;
    logic          addr_ph;
    logic          wr_ph;

    // Position inside the current half of the machine cycle.
    always_comb begin
        upper = (pos_i >= HALF_C);
        ph    = upper ? (pos_i - HALF_C) : pos_i;
        fetch = (kind_i == KIND_FETCH);
    end

    // Strobe decode. The data cycle drops the second latch pulse and both reads.
    always_comb begin
        ale_o    = live_i && (ph < ALE_LEN_C) && (fetch || !upper);
        psen_n_o = !(live_i && fetch && (ph >= QTR_C));
        rd_n_o   = !(live_i && kind_i == KIND_READ && upper);
        wr_n_o   = !(live_i && kind_i == KIND_WRITE && upper);
    end

    // Lane and high-byte mux.
    always_comb begin
        addr_ph   = fetch ? (ph < QTR_C) : !upper;
        wr_ph     = (kind_i == KIND_WRITE) && upper;
        ad_oe_o   = live_i && (addr_ph || wr_ph);
        ad_o      = wr_ph ? wdata_i : (fetch ? pc_i[DATA_W-1:0] : lo_i);
        addr_hi_o = fetch ? pc_i[ADDR_W-1:DATA_W] : hi_i;
    end

    // External address latch model: capture in the last clock of a latch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_o <= '0;
        end else if (ale_o && ph == ALE_END_C) begin
            addr_lo_o <= ad_o;
        end
    end

    p_lane_off_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);
    p_psen_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != KIND_FETCH) |-> psen_n_o);
    p_ale_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != KIND_FETCH && upper) |-> !ale_o);
    p_hi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i != KIND_FETCH && pos_i != '0) |-> $stable(addr_hi_o));
    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_o) |-> (addr_lo_o == $past(ad_o)));
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n_o, !rd_n_o, !wr_n_o}) <= 1);
endmodule

// File: rtl/xbus_seq.sv
// External memory bus sequencer (top). It ties the position counter, the
// access control and the strobe decode together.
// Assumes: ADDR_W == 2*DATA_W. The core holds req_i until grant_o to make
// sure the request is accepted.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int STATE_CLKS = 2,
    parameter int NUM_STATES = 6,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic              req_wide_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] p2_reg_i,
    output logic              grant_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ale_o,
    output logic              psen_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] addr_hi_o,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe_o,
    input  logic [DATA_W-1:0] ad_i
);
    localparam int CYC = STATE_CLKS * NUM_STATES;
    localparam int CW  = $clog2(CYC);

    logic              live;
    logic [CW-1:0]     pos;
    logic              last;
    kind_e             kind;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] wdata_q;

    xbus_phase_ctr #(
        .STATE_CLKS(STATE_CLKS), .NUM_STATES(NUM_STATES), .CYC(CYC), .CW(CW)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .live_o(live), .pos_o(pos), .last_o(last)
    );

    xbus_access_ctl #(
        .STATE_CLKS(STATE_CLKS), .NUM_STATES(NUM_STATES),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC(CYC), .CW(CW)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .last_i(last), .pos_i(pos),
        .req_i(req_i), .req_we_i(req_we_i), .req_wide_i(req_wide_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .p2_reg_i(p2_reg_i), .ad_i(ad_i),
        .kind_o(kind), .hi_o(hi_q), .lo_o(lo_q), .wdata_o(wdata_q),
        .grant_o(grant_o), .done_o(done_o), .rdata_o(rdata_o)
    );

    xbus_strobe_gen #(
        .STATE_CLKS(STATE_CLKS), .NUM_STATES(NUM_STATES),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC(CYC), .CW(CW)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .live_i(live), .pos_i(pos), .kind_i(kind),
        .hi_i(hi_q), .lo_i(lo_q), .wdata_i(wdata_q), .pc_i(pc_i),
        .ale_o(ale_o), .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
        .addr_hi_o(addr_hi_o), .addr_lo_o(addr_lo_o),
        .ad_o(ad_o), .ad_oe_o(ad_oe_o)
    );

    p_reset_quiet_r11: assert property (@(posedge clk)
        !$past(rst_n) |-> (!ale_o && psen_n_o && rd_n_o && wr_n_o && !ad_oe_o)) ;
endmodule

// File: tb/tb_xbus_seq.sv
// Directed bench for the external bus sequencer. It keeps its own
// position count and checks each scenario in its own task.
module tb_xbus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = 16'h0000;
    logic        req_i = 1'b0;
    logic        req_we_i = 1'b0;
    logic        req_wide_i = 1'b0;
    logic [15:0] req_addr_i = 16'h0000;
    logic [7:0]  req_wdata_i = 8'h00;
    logic [7:0]  p2_reg_i = 8'h00;
    logic [7:0]  ad_i = 8'h00;
    logic        grant_o, done_o, ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o;
    logic [7:0]  rdata_o, addr_hi_o, addr_lo_o, ad_o;

    int total = 0;
    int bad = 0;
    int wd = 0;
    int tpos = 0;
    bit tlive = 1'b0;

    always #5 clk = ~clk;

    xbus_seq dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .req_i(req_i),
        .req_we_i(req_we_i), .req_wide_i(req_wide_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .p2_reg_i(p2_reg_i), .grant_o(grant_o),
        .done_o(done_o), .rdata_o(rdata_o), .ale_o(ale_o), .psen_n_o(psen_n_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .addr_hi_o(addr_hi_o),
        .addr_lo_o(addr_lo_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i)
    );

    // Bench's own position count, taken from the timing requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            tlive <= 1'b0;
            tpos  <= 0;
        end else if (!tlive) begin
            tlive <= 1'b1;
        end else begin
            tpos <= (tpos + 1) % 12;
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=20000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h (pos %0d)", req, act, exp, tpos);
        end
    endtask

    task automatic goto(input int p);
        @(negedge clk);
        while (!tlive || tpos != p) @(negedge clk);
    endtask

    // R11: outputs quiet in reset, and position 0 of a fetch cycle follows.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 ale in reset", ale_o, 0);
        check("R11 psen_n in reset", psen_n_o, 1);
        check("R11 rd_n in reset", rd_n_o, 1);
        check("R11 wr_n in reset", wr_n_o, 1);
        check("R11 ad_oe in reset", ad_oe_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 first clock is pos0 ale", ale_o, 1);
        check("R11 first clock psen_n", psen_n_o, 1);
        check("R11 first clock ad_oe", ad_oe_o, 1);
    endtask

    // R1, R2, R3, R4: one fetch machine cycle, position by position.
    task automatic t_fetch(input logic [15:0] pc);
        pc_i = pc;
        goto(0);
        for (int p = 0; p < 12; p++) begin
            if (p > 0) @(negedge clk);
            check("R1 fetch ale", ale_o, ((p % 6) < 2) ? 1 : 0);
            check("R2 fetch psen_n", psen_n_o, ((p % 6) >= 3) ? 0 : 1);
            check("R3 fetch ad_oe", ad_oe_o, ((p % 6) < 3) ? 1 : 0);
            if ((p % 6) < 3) check("R3 fetch lane addr", ad_o, pc[7:0]);
            check("R3 fetch addr_hi", addr_hi_o, pc[15:8]);
            if (p == 2 || p == 8) check("R4 low address latch", addr_lo_o, pc[7:0]);
        end
    endtask

    // R5-R10: one data access, with the request raised in mid-cycle.
    task automatic t_access(input bit we, input bit wide, input logic [15:0] addr,
                            input logic [7:0] wd8, input logic [7:0] p2,
                            input logic [7:0] good);
        logic [7:0] exp_hi;
        exp_hi = wide ? addr[15:8] : p2;
        goto(5);
        req_i = 1'b1; req_we_i = we; req_wide_i = wide;
        req_addr_i = addr; req_wdata_i = wd8; p2_reg_i = p2;
        goto(9);
        check("R5 fetch continues before boundary", psen_n_o, 0);
        check("R5 no early grant", grant_o, 0);
        goto(0);
        check("R5 grant at pos0", grant_o, 1);
        req_i = 1'b0;
        req_addr_i = 16'h0000; p2_reg_i = ~p2; req_wdata_i = ~wd8;
        for (int p = 0; p < 12; p++) begin
            if (p > 0) @(negedge clk);
            check("R6 data ale", ale_o, (p < 2) ? 1 : 0);
            check("R6 data psen_n", psen_n_o, 1);
            check("R7 data addr_hi", addr_hi_o, exp_hi);
            if (p < 6) begin
                check("R7 data lane addr oe", ad_oe_o, 1);
                check("R7 data lane addr", ad_o, addr[7:0]);
            end
            if (p == 2) check("R4 data address latch", addr_lo_o, addr[7:0]);
            if (we) begin
                check("R10 wr_n", wr_n_o, (p >= 6) ? 0 : 1);
                check("R10 rd_n", rd_n_o, 1);
                if (p >= 6) begin
                    check("R10 lane oe", ad_oe_o, 1);
                    check("R10 lane wdata", ad_o, wd8);
                end
            end else begin
                check("R8 rd_n", rd_n_o, (p >= 6) ? 0 : 1);
                check("R8 wr_n", wr_n_o, 1);
                if (p >= 6) check("R8 lane released", ad_oe_o, 0);
                ad_i = (p == 10) ? good : ~good;
            end
        end
        @(negedge clk);
        if (we) check("R10 done pulse", done_o, 1);
        else begin
            check("R9 done pulse", done_o, 1);
            check("R9 read data", rdata_o, good);
        end
        check("R5 no second grant", grant_o, 0);
        check("R2 fetch resumes psen_n", psen_n_o, 1);
        @(negedge clk);
        check("R9 done is one clock", done_o, 0);
    endtask

    // R5: a request dropped before position 11 is ignored.
    task automatic t_short_req;
        goto(4);
        req_i = 1'b1; req_we_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        goto(0);
        check("R5 short request no grant", grant_o, 0);
        goto(3);
        check("R5 short request fetch psen_n", psen_n_o, 0);
        goto(7);
        check("R5 short request second ale", ale_o, 1);
    endtask

    // R12: back-to-back accesses hold off fetches for two full cycles.
    task automatic t_b2b;
        int ale_n;
        int psen_n;
        int grants;
        ale_n = 0; psen_n = 0; grants = 0;
        goto(6);
        req_i = 1'b1; req_we_i = 1'b1; req_wide_i = 1'b1;
        req_addr_i = 16'h7E11; req_wdata_i = 8'h5A;
        goto(0);
        for (int k = 0; k < 24; k++) begin
            if (k > 0) @(negedge clk);
            if (ale_o) ale_n++;
            if (!psen_n_o) psen_n++;
            if (grant_o) grants++;
            if (k == 13) req_i = 1'b0;
        end
        check("R12 ale clocks over two data cycles", 16'(ale_n), 4);
        check("R12 psen_n lows over two data cycles", 16'(psen_n), 0);
        check("R12 grants", 16'(grants), 2);
        goto(3);
        check("R12 fetch after pair", psen_n_o, 0);
    endtask

    initial begin
        t_reset();
        t_fetch(16'hA53C);
        t_fetch(16'h1C96);
        t_access(1'b0, 1'b1, 16'hB2C4, 8'h00, 8'h3E, 8'hA7);
        t_access(1'b1, 1'b0, 16'h00F1, 8'h6D, 8'h9B, 8'h00);
        t_access(1'b0, 1'b0, 16'h4410, 8'h00, 8'hE2, 8'h19);
        t_short_req();
        t_b2b();
        t_reset();
        t_fetch(16'h0F0F);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule